// File: doc/BRIEF.md
# Double-Buffered PWM Timer Bank

The block is a bank of five down-counting timer channels behind a small synchronous register bus. Channels 0 to 3 each drive one PWM output. Channel 4 has no compare register and no output, and serves only as a periodic interrupt source. Every channel counts on its own tick enable. A tick is made from the core clock by one of two shared 8-bit prescalers, followed by a per-channel power-of-two divider. Prescaler 0 feeds channels 0 and 1. Prescaler 1 feeds channels 2, 3 and 4.

Software writes the period value and the duty value of a channel into shadow buffers. Those values reach the working counter and compare registers at only two moments. The first is while the channel's update bit is held set. The second is at an underflow, and only when auto-reload is on. This lets a running waveform be retuned without glitches: the new values take over at a period boundary. Without auto-reload a channel runs for one period and then stops. Each underflow can raise a sticky interrupt flag, and software clears that flag by writing a one to it.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset, all registers read 0, every `pwm_o` bit is 0 and every `irq_o` bit is 0.
- R2: The register at word address 0 holds prescaler 0 in bits [7:0] and prescaler 1 in bits [15:8]. The register at address 1 holds a 4-bit divider select for channel c at bits [4c+3:4c]. A select s of 0 to 4 divides by 2^s, and any larger select divides by 16. Channel c ticks at the clock rate / (prescaler + 1) / 2^s.
- R3: With count buffer N and compare buffer M, where M < N, a running channel repeats with a period of N+1 ticks. Its raw output is high while the counter is at or below M, which is M+1 ticks per period.
- R4: The control register is at address 2. Channel c has a 4-bit group at base 0, 8, 12, 16 or 20 for c = 0 to 4. Within a group, bit +0 is start, +1 is update, +2 is invert and +3 is auto-reload. All other control bits read as 0.
- R5: While a channel's update bit is set, the counter and compare registers are loaded from the buffers every clock, and counting is held.
- R6: With auto-reload set, an underflow copies both buffers into the working registers. A buffer written during a period therefore takes effect from the next period on.
- R7: With auto-reload clear, the channel underflows once. It then stops with its raw output at 0 and makes no further underflow until the update bit is set again.
- R8: `pwm_o[c]` is the raw output of channel c XOR its invert bit. For a channel that is not started, this makes `pwm_o[c]` equal to the invert bit.
- R9: The register at address 3 holds the interrupt status in bits [4:0] and the interrupt enables in bits [12:8]. A status bit is set on an underflow of that channel only while its enable is set. Writing 1 to a status bit clears it, but an underflow in the same cycle keeps it set. `irq_o` shows the status bits.
- R10: The count buffers of channels 0 to 4 are at addresses 4 to 8 and the compare buffers of channels 0 to 3 at addresses 9 to 12. All of them are 32 bits and read back as written. Address 13 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pwm_o | output | 4 | PWM outputs of channels 0 to 3 |
| irq_o | output | 5 | Interrupt status of channels 0 to 4 |

## Verification
The properties assume that each write is a single-cycle strobe with its address and data stable at the clock edge. The counter-step and reload properties also assume that the buffers a channel loads from are not rewritten in the same cycle as the load. The stimulus reconfigures prescalers, dividers and buffers only while the affected channel is stopped, with one exception: the deliberate mid-period buffer change of R6, which lands one cycle away from any load. Waveform checks use compare values below the count value, so that every period has one rising edge and one falling edge. Period and high time are measured edge to edge, which keeps the checks independent of the free-running prescaler phase.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int NUM_CH       = 5;
  localparam int NUM_PWM      = 4;
  localparam int NUM_GRP      = 2;
  localparam int DIV_MAX_LOG2 = 4;
  localparam int CTRL_GRP_W   = 4;
  localparam int IRQ_EN_LSB   = 8;

  localparam int A_PSC  = 0;
  localparam int A_DIV  = 1;
  localparam int A_CTRL = 2;
  localparam int A_IRQ  = 3;
  localparam int A_CNTB = 4;
  localparam int A_CMPB = A_CNTB + NUM_CH;

  // bit order matches the control group layout, start at +0
  typedef struct packed {
    logic reload;
    logic invert;
    logic update;
    logic start;
  } ch_ctrl_t;

  function automatic int ctrl_base(input int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int psc_group(input int ch);
    return (ch < 2) ? 0 : 1;
  endfunction
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_timer_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int SEL_W = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_GRP-1:0][PSC_W-1:0]    psc_i,
  input  logic [NUM_CH-1:0][SEL_W-1:0]     sel_i,
  output logic [NUM_CH-1:0]                tick_o
);
  localparam int DW = DIV_MAX_LOG2;

  logic [PSC_W-1:0] pre_q [NUM_GRP];
  logic [DW-1:0]    div_q [NUM_GRP];
  logic [NUM_GRP-1:0] pulse;

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) pulse[g] = (pre_q[g] >= psc_i[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_GRP; g++) begin
        pre_q[g] <= '0;
        div_q[g] <= '0;
      end
    end else begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (pulse[g]) begin
          pre_q[g] <= '0;
          div_q[g] <= div_q[g] + 1'b1;
        end else begin
          pre_q[g] <= pre_q[g] + 1'b1;
        end
      end
    end
  end

  function automatic logic [DW-1:0] sel_mask(input logic [SEL_W-1:0] s);
    logic [DW-1:0] m;
    m = '0;
    for (int b = 0; b < DW; b++) if (SEL_W'(b) < s) m[b] = 1'b1;
    return m;
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_tick
    localparam int G = psc_group(c);
    logic [DW-1:0] mask;
    assign mask      = sel_mask(sel_i[c]);
    assign tick_o[c] = pulse[G] && ((div_q[G] & mask) == mask);
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W   = 32,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             update_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] cnt_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             uflow_o,
  output logic             raw_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             load;

  assign run_o   = start_i && !done_q;
  assign uflow_o = tick_i && run_o && !update_i && (cnt_q == '0);
  assign load    = update_i || (uflow_o && reload_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (update_i) begin
      cnt_q  <= cnt_buf_i;
      done_q <= 1'b0;
    end else if (tick_i && run_o) begin
      if (cnt_q != '0)   cnt_q  <= cnt_q - 1'b1;
      else if (reload_i) cnt_q  <= cnt_buf_i;
      else               done_q <= 1'b1;
    end
  end

  if (HAS_CMP) begin : g_cmp
    logic [CNT_W-1:0] cmp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cmp_q <= '0;
      else if (load) cmp_q <= cmp_buf_i;
    end
    assign raw_o = run_o && (cnt_q <= cmp_q);
  end else begin : g_nocmp
    logic unused_cmp;
    assign unused_cmp = ^{cmp_buf_i, load};
    assign raw_o      = 1'b0;
  end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSC_W  = 8,
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [DATA_W-1:0]                  rdata_o,
  input  logic [NUM_CH-1:0]                  uflow_i,
  output logic [NUM_GRP-1:0][PSC_W-1:0]      psc_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]       sel_o,
  output ch_ctrl_t [NUM_CH-1:0]              ctrl_o,
  output logic [NUM_CH-1:0]                  irq_en_o,
  output logic [NUM_CH-1:0]                  irq_st_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]      cnt_buf_o,
  output logic [NUM_PWM-1:0][DATA_W-1:0]     cmp_buf_o
);
  logic wr_psc, wr_div, wr_ctrl, wr_irq;

  assign wr_psc  = wr_en_i && (addr_i == ADDR_W'(A_PSC));
  assign wr_div  = wr_en_i && (addr_i == ADDR_W'(A_DIV));
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(A_CTRL));
  assign wr_irq  = wr_en_i && (addr_i == ADDR_W'(A_IRQ));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_o    <= '0;
      sel_o    <= '0;
      ctrl_o   <= '0;
      irq_en_o <= '0;
    end else begin
      if (wr_psc) psc_o <= wdata_i[NUM_GRP*PSC_W-1:0];
      if (wr_div) sel_o <= wdata_i[NUM_CH*SEL_W-1:0];
      if (wr_ctrl)
        for (int c = 0; c < NUM_CH; c++)
          ctrl_o[c] <= ch_ctrl_t'(wdata_i[ctrl_base(c) +: CTRL_GRP_W]);
      if (wr_irq) irq_en_o <= wdata_i[IRQ_EN_LSB +: NUM_CH];
    end
  end

  // set has priority over the write-one clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_st_o <= '0;
    else
      for (int c = 0; c < NUM_CH; c++) begin
        if (uflow_i[c] && irq_en_o[c])  irq_st_o[c] <= 1'b1;
        else if (wr_irq && wdata_i[c])  irq_st_o[c] <= 1'b0;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_buf_o <= '0;
      cmp_buf_o <= '0;
    end else if (wr_en_i) begin
      for (int c = 0; c < NUM_CH; c++)
        if (addr_i == ADDR_W'(A_CNTB + c)) cnt_buf_o[c] <= wdata_i;
      for (int p = 0; p < NUM_PWM; p++)
        if (addr_i == ADDR_W'(A_CMPB + p)) cmp_buf_o[p] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_PSC))  rdata_o[NUM_GRP*PSC_W-1:0] = psc_o;
    if (addr_i == ADDR_W'(A_DIV))  rdata_o[NUM_CH*SEL_W-1:0]  = sel_o;
    if (addr_i == ADDR_W'(A_CTRL))
      for (int c = 0; c < NUM_CH; c++) rdata_o[ctrl_base(c) +: CTRL_GRP_W] = ctrl_o[c];
    if (addr_i == ADDR_W'(A_IRQ)) begin
      rdata_o[NUM_CH-1:0]             = irq_st_o;
      rdata_o[IRQ_EN_LSB +: NUM_CH]   = irq_en_o;
    end
    for (int c = 0; c < NUM_CH; c++)
      if (addr_i == ADDR_W'(A_CNTB + c)) rdata_o = cnt_buf_o[c];
    for (int p = 0; p < NUM_PWM; p++)
      if (addr_i == ADDR_W'(A_CMPB + p)) rdata_o = cmp_buf_o[p];
  end
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSC_W  = 8,
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_PWM-1:0] pwm_o,
  output logic [NUM_CH-1:0]  irq_o
);
  logic [NUM_GRP-1:0][PSC_W-1:0]  psc;
  logic [NUM_CH-1:0][SEL_W-1:0]   sel;
  ch_ctrl_t [NUM_CH-1:0]          ctrl;
  logic [NUM_CH-1:0]              irq_en, irq_st;
  logic [NUM_CH-1:0][DATA_W-1:0]  cnt_buf;
  logic [NUM_PWM-1:0][DATA_W-1:0] cmp_buf;
  logic [NUM_CH-1:0]              tick, chan_run, chan_uflow, chan_raw;
  logic [NUM_CH-1:0][DATA_W-1:0]  chan_cnt;

  pwm_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .uflow_i(chan_uflow), .psc_o(psc), .sel_o(sel), .ctrl_o(ctrl),
    .irq_en_o(irq_en), .irq_st_o(irq_st), .cnt_buf_o(cnt_buf), .cmp_buf_o(cmp_buf)
  );

  pwm_tick_gen #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_tick (
    .clk_i, .rst_ni, .psc_i(psc), .sel_i(sel), .tick_o(tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] cmp_b;
    if (c < NUM_PWM) begin : g_has
      assign cmp_b    = cmp_buf[c];
      assign pwm_o[c] = chan_raw[c] ^ ctrl[c].invert;
    end else begin : g_tick_only
      assign cmp_b = '0;
    end
    pwm_chan #(.CNT_W(DATA_W), .HAS_CMP(c < NUM_PWM)) u_chan (
      .clk_i, .rst_ni,
      .tick_i(tick[c]), .start_i(ctrl[c].start), .update_i(ctrl[c].update),
      .reload_i(ctrl[c].reload), .cnt_buf_i(cnt_buf[c]), .cmp_buf_i(cmp_b),
      .cnt_o(chan_cnt[c]), .run_o(chan_run[c]), .uflow_o(chan_uflow[c]), .raw_o(chan_raw[c])
    );
  end

  logic unused_tick_only;
  assign unused_tick_only = ^{chan_raw[NUM_CH-1], ctrl[NUM_CH-1].invert};

  assign irq_o = irq_st;
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [NUM_CH-1:0]             clr_bits,
  input logic [NUM_CH-1:0]             tick,
  input logic [NUM_CH-1:0]             chan_run,
  input logic [NUM_CH-1:0]             chan_uflow,
  input logic [NUM_CH-1:0][DATA_W-1:0] chan_cnt,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt_buf,
  input ch_ctrl_t [NUM_CH-1:0]         ctrl,
  input logic [NUM_CH-1:0]             irq_en,
  input logic [NUM_CH-1:0]             irq_st
);
  logic wr_irq;
  assign wr_irq = wr_en_i && (addr_i == ADDR_W'(A_IRQ));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick[c] && chan_run[c] && !ctrl[c].update && chan_cnt[c] != '0)
      |=> chan_cnt[c] == $past(chan_cnt[c]) - 1'b1);

    p_hold_update_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl[c].update |=> chan_cnt[c] == $past(cnt_buf[c]));

    p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chan_uflow[c] && ctrl[c].reload) |=> chan_cnt[c] == $past(cnt_buf[c]));

    p_oneshot_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chan_uflow[c] && !ctrl[c].reload) |=> !chan_run[c]);

    p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!irq_en[c] && !irq_st[c]) |=> !irq_st[c]);

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chan_uflow[c] && irq_en[c]) |=> irq_st[c]);

    p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_st[c] && wr_irq && clr_bits[c] && !chan_uflow[c]) |=> !irq_st[c]);
  end
endmodule

bind pwm_timer_bank pwm_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .clr_bits(wdata_i[pwm_timer_pkg::NUM_CH-1:0]), .tick(tick), .chan_run(chan_run),
  .chan_uflow(chan_uflow), .chan_cnt(chan_cnt), .cnt_buf(cnt_buf), .ctrl(ctrl),
  .irq_en(irq_en), .irq_st(irq_st)
);

// File: tb/tb_pwm_timer_bank.sv
`timescale 1ns/1ps
module tb_pwm_timer_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  pwm_o;
  logic [4:0]  irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam int ST = 1, UP = 2, INV = 4, RL = 8;
  // ch, prescaler, divider select, count, compare, period clocks, high clocks
  localparam int NV = 8;
  localparam int VEC [NV][7] = '{
    '{0, 0, 0, 9, 4,  10,  5},
    '{0, 1, 1, 4, 1,  20,  8},
    '{0, 4, 4, 1, 0, 160, 80},
    '{1, 0, 2, 7, 2,  32, 12},
    '{0, 2, 3, 3, 1,  96, 48},
    '{2, 3, 0, 5, 2,  24, 12},
    '{3, 0, 1, 2, 0,   6,  2},
    '{1, 1, 0, 3, 2,   8,  6}
  };

  pwm_timer_bank dut (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o, .pwm_o, .irq_o
  );

  always #4 clk_i = ~clk_i;

  function automatic int gbase(input int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr_i = a[3:0]; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr_i = a[3:0];
    #1;
    d = rdata_o;
  endtask

  task automatic wait_lvl(input int ch, input logic lvl);
    int n = 0;
    while (pwm_o[ch] !== lvl && n < 3000) begin @(negedge clk_i); n++; end
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    int lo = 0;
    hi = 0;
    wait_lvl(ch, 1'b1); wait_lvl(ch, 1'b0); wait_lvl(ch, 1'b1);
    while (pwm_o[ch] === 1'b1 && hi < 3000) begin @(negedge clk_i); hi++; end
    while (pwm_o[ch] === 1'b0 && lo < 3000) begin @(negedge clk_i); lo++; end
    per = hi + lo;
  endtask

  task automatic count_rises(input int ch, input int cycles, output int rises);
    logic prev = pwm_o[ch];
    rises = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (pwm_o[ch] === 1'b1 && prev === 1'b0) rises++;
      prev = pwm_o[ch];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi, per, r;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 pwm_o", {28'd0, pwm_o}, 32'd0);
    chk("R1 irq_o", {27'd0, irq_o}, 32'd0);
    rd(2, d); chk("R1 ctrl", d, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(5, d); chk("R1 count buffer", d, 32'd0);

    // R10 / R2 / R4 readback
    wr(7, 32'hDEADBEEF); rd(7, d); chk("R10 count buffer ch3", d, 32'hDEADBEEF);
    wr(12, 32'h0000A5A5); rd(12, d); chk("R10 compare buffer ch3", d, 32'h0000A5A5);
    wr(13, 32'h12345678); rd(13, d); chk("R10 unmapped reads 0", d, 32'd0);
    wr(0, 32'h12345678); rd(0, d); chk("R2 prescaler fields", d, 32'h00005678);
    wr(1, 32'hFFF12345); rd(1, d); chk("R2 divider fields", d, 32'h00012345);
    wr(2, 32'hFFFFFFFF); rd(2, d); chk("R4 control mask", d, 32'h00FFFF0F);
    wr(2, 32'h0);
    wr(2, UP << gbase(4)); wr(2, 32'h0);

    // R2 / R3 vector table
    for (int v = 0; v < NV; v++) begin
      int ch = VEC[v][0];
      wr(2, 32'h0);
      wr(0, (ch < 2) ? VEC[v][1] : (VEC[v][1] << 8));
      wr(1, VEC[v][2] << (4 * ch));
      wr(4 + ch, VEC[v][3]);
      wr(9 + ch, VEC[v][4]);
      wr(2, (UP | RL) << gbase(ch));
      wr(2, (ST | RL) << gbase(ch));
      measure(ch, hi, per);
      chk($sformatf("R2 R3 vector %0d period", v), per, VEC[v][5]);
      chk($sformatf("R3 vector %0d high time", v), hi, VEC[v][6]);
    end
    rd(3, d); chk("R9 no status without enable", d, 32'd0);

    // R6 buffer change lands at next underflow
    wr(2, 32'h0); wr(0, 0); wr(1, 0);
    wr(4, 9); wr(9, 4);
    wr(2, UP | RL); wr(2, ST | RL);
    repeat (15) @(negedge clk_i);
    wr(4, 19);
    repeat (25) @(negedge clk_i);
    measure(0, hi, per);
    chk("R6 new period after reload", per, 20);

    // R8 inverter
    wr(2, INV << gbase(3));
    chk("R8 stopped inverted output", {31'd0, pwm_o[3]}, 32'd1);
    wr(2, 32'h0);
    wr(4, 9); wr(9, 2);
    wr(2, UP | RL | INV); wr(2, ST | RL | INV);
    measure(0, hi, per);
    chk("R8 inverted high time", hi, 7);
    chk("R8 inverted period", per, 10);

    // R5 held in update
    wr(2, 32'h0); wr(4, 3); wr(9, 1);
    wr(2, ST | UP | RL);
    count_rises(0, 40, r);
    chk("R5 no output while update held", r, 0);
    wr(2, ST | RL);
    count_rises(0, 20, r);
    chk("R5 runs after update cleared", (r >= 1) ? 1 : 0, 1);

    // R7 one-shot with interrupt on ch1
    wr(2, 32'h0); wr(5, 3); wr(10, 1);
    wr(3, 1 << 9);
    wr(2, UP << gbase(1));
    wr(2, ST << gbase(1));
    count_rises(1, 30, r);
    chk("R7 single pulse", r, 1);
    chk("R7 output low after stop", {31'd0, pwm_o[1]}, 32'd0);
    chk("R9 irq_o set by underflow", {27'd0, irq_o}, 32'h2);
    wr(3, (1 << 9) | 2);
    rd(3, d); chk("R9 write one clears", d, 32'h200);
    count_rises(1, 30, r);
    rd(3, d); chk("R7 no further underflow", d, 32'h200);
    wr(2, 32'h0); wr(3, 0);

    // R9 set wins over clear, ch4 ticking every clock
    wr(0, 0); wr(1, 0); wr(8, 4);
    wr(3, 1 << 12);
    wr(2, (UP | RL) << gbase(4));
    wr(2, (ST | RL) << gbase(4));
    repeat (9) @(negedge clk_i);
    wr(3, (1 << 12) | (1 << 4));
    rd(3, d); chk("R9 set wins over clear", d, 32'h1010);
    wr(3, (1 << 12) | (1 << 4));
    rd(3, d); chk("R9 clear between underflows", d, 32'h1000);
    wr(2, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule